// File: doc/BRIEF.md
# Host Port Access Mode Gate

This block sits on the slave side of a host port. An external host processor uses it to read and write a DSP's 24-bit byte-addressed memory space and its public peripheral bus. The DSP core uses the same resources, so some of them are contended. Every transfer starts at the host. The DSP side only raises per-region requests and receives grants.

A two-bit mode input selects one of four access policies:

| Code | Policy | Regions the host may reach | DSP core |
|------|--------|----------------------------|----------|
| 0 | Shared memory | The three memory regions | Arbitrated against the host |
| 1 | Shared peripheral | The public peripheral bus only | Arbitrated against the host |
| 2 | Host-owned memory | Single-access RAM only | Locked out of that RAM |
| 3 | Host-owned peripheral | The public peripheral bus only | Locked out of that bus |

**Request flow.**
- A request is accepted over a valid/ready handshake and decoded into a region.
- The gate checks the region against the mode.
- An allowed access waits for its region grant and then performs a single-cycle target access.
- A refused access never reaches the target. It completes with an error.

**Back-pressure rules.**
- `req_ready_o` is high only while no transfer is outstanding.
- The response is held stable until the host takes it with `rsp_ready_i`.
- The next request is not accepted before that.

**Status and debug.** Sticky error, busy and mode status are plain pins. So are debug copies of the last completed transfer.

Top module: `hpg_gate`

## Requirements
- R1: A request is accepted only when `req_ready_o` is high, and `req_ready_o` is high only with no transfer outstanding. Each accepted request yields exactly one response. While `rsp_valid_o` is high and `rsp_ready_i` is low, the response fields stay unchanged.
- R2: Byte addresses decode by ascending window, with region codes as follows:
  - `0` single-access RAM: below `0x040000`.
  - `1` dual-access RAM: `0x040000` up to below `0x050000`.
  - `5` unmapped: `0x050000` up to below `0x100000`.
  - `2` external memory: `0x100000` up to below `0xF00000`.
  - `3` public peripheral: `0xF00000` up to below `0xF80000`.
  - `4` private peripheral: `0xF80000` and above.
  - An allowed access drives `tgt_valid_o` for one cycle with that region code on `tgt_region_o`.
- R3: Mode 0 allows regions 0, 1 and 2 and refuses region 3. Mode 1 allows only region 3.
- R4: Mode 2 allows only region 0. While in mode 2, `dsp_gnt_o[0]` stays low whatever the DSP requests.
- R5: Mode 3 allows only region 3. While in mode 3, `dsp_gnt_o[3]` stays low.
- R6: Private peripheral (region 4) and unmapped (region 5) addresses are refused in every mode.
- R7: A refused access never raises `tgt_valid_o`. It responds with `rsp_err_o`=1 and zero read data.
- R8: A refusal sets `stat_err_o`. It stays set until a cycle with `err_clr_i` high and no new refusal, which clears it.
- R9: In shared modes each of regions 0..3 has a round-robin between host and DSP. Host priority holds from reset. While both sides request, the grant alternates cycle by cycle. The host never has a target access in a cycle in which the DSP holds the same region.
- R10: A completed transfer updates the debug outputs:
  - `dbg_addr_o` takes the address.
  - `dbg_write_o` takes the direction.
  - `dbg_data_o` takes the write data, or for a read the returned data (zero if refused).
- R11: `stat_mode_o` shows the mode input. `stat_busy_o` is high from acceptance until the response is taken. A completed write returns zero read data, and an allowed read returns `tgt_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Access mode code (0..3, see R3-R5) |
| err_clr_i | input | 1 | Write-one pulse clearing the sticky error |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Gate can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 24 | Byte address |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Host takes the response |
| rsp_err_o | output | 1 | Access was refused |
| rsp_rdata_o | output | 16 | Read data |
| dsp_req_i | input | 4 | DSP core request per region 0..3 |
| dsp_gnt_o | output | 4 | DSP core grant per region 0..3 |
| tgt_valid_o | output | 1 | One-cycle access to the target region |
| tgt_region_o | output | 3 | Region code of the access |
| tgt_write_o | output | 1 | Access direction |
| tgt_addr_o | output | 24 | Access byte address |
| tgt_wdata_o | output | 16 | Access write data |
| tgt_rdata_i | input | 16 | Target read data, sampled in the access cycle |
| stat_mode_o | output | 2 | Current mode |
| stat_busy_o | output | 1 | Transfer outstanding |
| stat_err_o | output | 1 | Sticky refusal flag |
| dbg_addr_o | output | 24 | Address of last completed transfer |
| dbg_data_o | output | 16 | Data of last completed transfer |
| dbg_write_o | output | 1 | Direction of last completed transfer |

## Verification
Reads and writes go to every region under all four modes. This separates a decode fault (wrong `tgt_region_o` or wrong read data) from a permission fault (an error where an access was expected, or the reverse). The unmapped hole and the private window are tried in several modes, so a refusal tied to one mode does not hide a missing global block. A DSP request held high while the host makes two consecutive accesses to the same region checks the round-robin. The first access must finish at the uncontended latency, and the second must lose exactly one cycle to the DSP. The same held request in host-owned modes must never produce a DSP grant. A response held under back-pressure separates a correct hold from a response that is dropped or changes.

// File: rtl/hpg_pkg.sv
package hpg_pkg;
  localparam int unsigned HPG_NSH = 4;  // regions that can be granted

  typedef enum logic [1:0] {
    MODE_SH_MEM = 2'd0,
    MODE_SH_PER = 2'd1,
    MODE_HO_MEM = 2'd2,
    MODE_HO_PER = 2'd3
  } hpg_mode_e;

  typedef enum logic [2:0] {
    RG_SRAM = 3'd0,
    RG_DRAM = 3'd1,
    RG_XMEM = 3'd2,
    RG_PUB  = 3'd3,
    RG_PRIV = 3'd4,
    RG_NONE = 3'd5
  } hpg_region_e;

  typedef struct packed {
    logic ok;    // host may reach the region
    logic excl;  // host owns the region outright
  } hpg_perm_t;

  function automatic hpg_perm_t hpg_permit(hpg_mode_e m, hpg_region_e r);
    hpg_perm_t p;
    p = '0;
    case (m)
      MODE_SH_MEM: p.ok = (r == RG_SRAM) || (r == RG_DRAM) || (r == RG_XMEM);
      MODE_SH_PER: p.ok = (r == RG_PUB);
      MODE_HO_MEM: begin
        p.ok   = (r == RG_SRAM);
        p.excl = (r == RG_SRAM);
      end
      default: begin
        p.ok   = (r == RG_PUB);
        p.excl = (r == RG_PUB);
      end
    endcase
    return p;
  endfunction
endpackage

// File: rtl/hpg_decode.sv
module hpg_decode
  import hpg_pkg::*;
#(
  parameter int unsigned     AW        = 24,
  parameter logic [AW-1:0]   DRAM_BASE = 24'h040000,
  parameter logic [AW-1:0]   HOLE_BASE = 24'h050000,
  parameter logic [AW-1:0]   XMEM_BASE = 24'h100000,
  parameter logic [AW-1:0]   PUB_BASE  = 24'hF00000,
  parameter logic [AW-1:0]   PRIV_BASE = 24'hF80000
) (
  input  logic [AW-1:0] addr,
  output hpg_region_e   region
);
  // Ascending windows: the highest base not above the address wins.
  always_comb begin
    if (addr >= PRIV_BASE)      region = RG_PRIV;
    else if (addr >= PUB_BASE)  region = RG_PUB;
    else if (addr >= XMEM_BASE) region = RG_XMEM;
    else if (addr >= HOLE_BASE) region = RG_NONE;
    else if (addr >= DRAM_BASE) region = RG_DRAM;
    else                        region = RG_SRAM;
  end
endmodule

// File: rtl/hpg_rr_arb.sv
module hpg_rr_arb #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] host_req,
  input  logic [N-1:0] dsp_req,
  input  logic [N-1:0] excl,
  output logic [N-1:0] host_gnt,
  output logic [N-1:0] dsp_gnt
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    logic host_prio_q;
    logic both;

    assign both        = host_req[i] & dsp_req[i] & ~excl[i];
    assign host_gnt[i] = host_req[i] & (excl[i] | ~dsp_req[i] | host_prio_q);
    assign dsp_gnt[i]  = dsp_req[i] & ~excl[i] & ~host_gnt[i];

    // Whoever wins a contended cycle yields priority to the other side.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    host_prio_q <= 1'b1;
      else if (both) host_prio_q <= ~host_gnt[i];
    end
  end
endmodule

// File: rtl/hpg_gate.sv
module hpg_gate
  import hpg_pkg::*;
#(
  parameter int unsigned   AW        = 24,
  parameter int unsigned   DW        = 16,
  parameter logic [AW-1:0] DRAM_BASE = 24'h040000,
  parameter logic [AW-1:0] HOLE_BASE = 24'h050000,
  parameter logic [AW-1:0] XMEM_BASE = 24'h100000,
  parameter logic [AW-1:0] PUB_BASE  = 24'hF00000,
  parameter logic [AW-1:0] PRIV_BASE = 24'hF80000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              err_clr_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              rsp_err_o,
  output logic [DW-1:0]     rsp_rdata_o,
  input  logic [HPG_NSH-1:0] dsp_req_i,
  output logic [HPG_NSH-1:0] dsp_gnt_o,
  output logic              tgt_valid_o,
  output logic [2:0]        tgt_region_o,
  output logic              tgt_write_o,
  output logic [AW-1:0]     tgt_addr_o,
  output logic [DW-1:0]     tgt_wdata_o,
  input  logic [DW-1:0]     tgt_rdata_i,
  output logic [1:0]        stat_mode_o,
  output logic              stat_busy_o,
  output logic              stat_err_o,
  output logic [AW-1:0]     dbg_addr_o,
  output logic [DW-1:0]     dbg_data_o,
  output logic              dbg_write_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} st_e;

  st_e              state_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic             write_q;
  logic [DW-1:0]    rdata_q;
  logic             err_q;
  logic             sticky_q;
  logic [AW-1:0]    dbg_addr_q;
  logic [DW-1:0]    dbg_data_q;
  logic             dbg_write_q;

  hpg_mode_e        mode;
  hpg_region_e      region;
  logic             allowed;
  logic             refuse;
  logic             fire;
  logic [HPG_NSH-1:0] host_req, host_gnt, excl;
  logic [DW-1:0]    done_data;

  assign mode = hpg_mode_e'(mode_i);

  hpg_decode #(
    .AW(AW), .DRAM_BASE(DRAM_BASE), .HOLE_BASE(HOLE_BASE),
    .XMEM_BASE(XMEM_BASE), .PUB_BASE(PUB_BASE), .PRIV_BASE(PRIV_BASE)
  ) u_decode (
    .addr  (addr_q),
    .region(region)
  );

  assign allowed = hpg_permit(mode, region).ok;
  assign refuse  = (state_q == ST_WAIT) && !allowed;

  for (genvar i = 0; i < HPG_NSH; i++) begin : g_region
    assign excl[i]     = hpg_permit(mode, hpg_region_e'(3'(i))).excl;
    assign host_req[i] = (state_q == ST_WAIT) && allowed &&
                         (region == hpg_region_e'(3'(i)));
  end

  hpg_rr_arb #(.N(HPG_NSH)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .host_req(host_req),
    .dsp_req (dsp_req_i),
    .excl    (excl),
    .host_gnt(host_gnt),
    .dsp_gnt (dsp_gnt_o)
  );

  assign fire      = |host_gnt;
  assign done_data = write_q ? wdata_q : (refuse ? '0 : tgt_rdata_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      write_q     <= 1'b0;
      rdata_q     <= '0;
      err_q       <= 1'b0;
      dbg_addr_q  <= '0;
      dbg_data_q  <= '0;
      dbg_write_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          write_q <= req_write_i;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (refuse || fire) begin
          err_q       <= refuse;
          rdata_q     <= (refuse || write_q) ? '0 : tgt_rdata_i;
          dbg_addr_q  <= addr_q;
          dbg_data_q  <= done_data;
          dbg_write_q <= write_q;
          state_q     <= ST_RESP;
        end
        default: if (rsp_ready_i) state_q <= ST_IDLE;
      endcase
    end
  end

  // Sticky refusal flag: a new refusal beats a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sticky_q <= 1'b0;
    else if (refuse)    sticky_q <= 1'b1;
    else if (err_clr_i) sticky_q <= 1'b0;
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign rsp_valid_o  = (state_q == ST_RESP);
  assign rsp_err_o    = err_q;
  assign rsp_rdata_o  = rdata_q;
  assign tgt_valid_o  = fire;
  assign tgt_region_o = region;
  assign tgt_write_o  = write_q;
  assign tgt_addr_o   = addr_q;
  assign tgt_wdata_o  = wdata_q;
  assign stat_mode_o  = mode_i;
  assign stat_busy_o  = (state_q != ST_IDLE);
  assign stat_err_o   = sticky_q;
  assign dbg_addr_o   = dbg_addr_q;
  assign dbg_data_o   = dbg_data_q;
  assign dbg_write_o  = dbg_write_q;
endmodule

// File: rtl/hpg_gate_chk.sv
module hpg_gate_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_i,
  input logic          err_clr_i,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic          rsp_ready_i,
  input logic          rsp_err_o,
  input logic [DW-1:0] rsp_rdata_o,
  input logic [3:0]    dsp_gnt_o,
  input logic          tgt_valid_o,
  input logic [2:0]    tgt_region_o,
  input logic          stat_err_o
);
  a_r1_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_err_o));

  a_r1_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> !req_ready_o);

  a_r4_sram_owned: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'd2 |-> !dsp_gnt_o[0]);

  a_r5_pub_owned: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'd3 |-> !dsp_gnt_o[3]);

  a_r6_no_private: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid_o |-> tgt_region_o != 3'd4 && tgt_region_o != 3'd5);

  a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && rsp_err_o |-> rsp_rdata_o == '0);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stat_err_o && !err_clr_i |=> stat_err_o);

  a_r9_mutex: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid_o && tgt_region_o < 3'd4 |-> !dsp_gnt_o[tgt_region_o[1:0]]);
endmodule

bind hpg_gate hpg_gate_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .err_clr_i   (err_clr_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_err_o   (rsp_err_o),
  .rsp_rdata_o (rsp_rdata_o),
  .dsp_gnt_o   (dsp_gnt_o),
  .tgt_valid_o (tgt_valid_o),
  .tgt_region_o(tgt_region_o),
  .stat_err_o  (stat_err_o)
);

// File: tb/hpg_gate_bench.sv
`timescale 1ns/1ps
module hpg_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        err_clr = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_err;
  logic [15:0] rsp_rdata;
  logic [3:0]  dsp_req = '0;
  logic [3:0]  dsp_gnt;
  logic        tgt_valid;
  logic [2:0]  tgt_region;
  logic        tgt_write;
  logic [23:0] tgt_addr;
  logic [15:0] tgt_wdata;
  logic [15:0] tgt_rdata;
  logic [1:0]  stat_mode;
  logic        stat_busy;
  logic        stat_err;
  logic [23:0] dbg_addr;
  logic [15:0] dbg_data;
  logic        dbg_write;

  int n_checks = 0;
  int n_fail   = 0;
  int tgt_hits = 0;
  logic [2:0] last_region = '0;

  always #5 clk = ~clk;

  // Target model: read data is a fixed function of the address.
  assign tgt_rdata = tgt_addr[16:1] ^ 16'h5A3C;

  hpg_gate u_hpg_gate (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .err_clr_i(err_clr),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_err_o(rsp_err),
    .rsp_rdata_o(rsp_rdata), .dsp_req_i(dsp_req), .dsp_gnt_o(dsp_gnt),
    .tgt_valid_o(tgt_valid), .tgt_region_o(tgt_region), .tgt_write_o(tgt_write),
    .tgt_addr_o(tgt_addr), .tgt_wdata_o(tgt_wdata), .tgt_rdata_i(tgt_rdata),
    .stat_mode_o(stat_mode), .stat_busy_o(stat_busy), .stat_err_o(stat_err),
    .dbg_addr_o(dbg_addr), .dbg_data_o(dbg_data), .dbg_write_o(dbg_write)
  );

  typedef struct {
    logic        err;
    logic [15:0] rdata;
    logic [23:0] addr;
    logic [15:0] data;
    logic        write;
    string       rq;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_rd(input logic [23:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction

  // Driver: pushes the expected response then hands the request over.
  task automatic send(input logic wr, input logic [23:0] a, input logic [15:0] d,
                      input logic refused, input string rq);
    exp_t e;
    e.err   = refused;
    e.rdata = (refused || wr) ? 16'h0 : model_rd(a);
    e.addr  = a;
    e.data  = wr ? d : e.rdata;
    e.write = wr;
    e.rq    = rq;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // Count negedges until a response shows; count DSP grants of a region meanwhile.
  task automatic wait_rsp(input int reg_idx, output int lat, output int dsp_cnt);
    lat = 0;
    dsp_cnt = 0;
    do begin
      @(negedge clk);
      lat++;
      if (!rsp_valid && dsp_gnt[reg_idx]) dsp_cnt++;
    end while (!rsp_valid && lat < 50);
  endtask

  // Monitor: compares every taken response with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && tgt_valid) begin
      tgt_hits++;
      last_region = tgt_region;
    end
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R1", "response with nothing outstanding", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_err == e.err, e.rq, "rsp_err", 32'(rsp_err), 32'(e.err));
        chk(rsp_rdata == e.rdata, e.err ? "R7" : "R11", "rsp_rdata",
            32'(rsp_rdata), 32'(e.rdata));
        chk(dbg_addr == e.addr && dbg_data == e.data && dbg_write == e.write,
            "R10", "debug addr/data/dir", {dbg_write, dbg_addr[14:0], dbg_data},
            {e.write, e.addr[14:0], e.data});
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : stim
    int lat, dc, hits0;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // Reset state
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk(stat_busy == 1'b0 && stat_err == 1'b0, "R11", "busy/err after reset",
        {stat_busy, stat_err}, 32'd0);
    rst_n = 1'b1;
    idle(2);

    // Mode 0: shared memory
    mode = 2'd0;
    send(1'b0, 24'h000124, 16'h0, 1'b0, "R2");
    wait_rsp(0, lat, dc);
    chk(last_region == 3'd0, "R2", "region sram", 32'(last_region), 32'd0);
    chk(lat == 2, "R2", "uncontended latency", 32'(lat), 32'd2);
    send(1'b0, 24'h040010, 16'h0, 1'b0, "R2");
    wait_rsp(1, lat, dc);
    chk(last_region == 3'd1, "R2", "region dram", 32'(last_region), 32'd1);
    send(1'b0, 24'h200000, 16'h0, 1'b0, "R3");
    wait_rsp(2, lat, dc);
    chk(last_region == 3'd2, "R2", "region xmem", 32'(last_region), 32'd2);
    send(1'b1, 24'h00AA02, 16'hBEEF, 1'b0, "R11");
    wait_rsp(0, lat, dc);
    chk(tgt_write == 1'b1 || last_region == 3'd0, "R2", "write to sram", 32'(last_region), 32'd0);
    idle(2);
    hits0 = tgt_hits;
    send(1'b0, 24'hF00100, 16'h0, 1'b1, "R3");
    send(1'b0, 24'hF80000, 16'h0, 1'b1, "R6");
    send(1'b1, 24'h060000, 16'h1234, 1'b1, "R6");
    idle(3);
    chk(tgt_hits == hits0, "R7", "no target access when refused", 32'(tgt_hits), 32'(hits0));
    chk(stat_err == 1'b1, "R8", "sticky error set", 32'(stat_err), 32'd1);
    idle(3);
    chk(stat_err == 1'b1, "R8", "sticky error held", 32'(stat_err), 32'd1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk(stat_err == 1'b0, "R8", "sticky error cleared", 32'(stat_err), 32'd0);

    // Mode 1: shared peripheral
    mode = 2'd1;
    @(negedge clk);
    chk(stat_mode == 2'd1, "R11", "stat_mode", 32'(stat_mode), 32'd1);
    send(1'b0, 24'hF00200, 16'h0, 1'b0, "R3");
    wait_rsp(3, lat, dc);
    chk(last_region == 3'd3, "R2", "region pub", 32'(last_region), 32'd3);
    send(1'b0, 24'h000300, 16'h0, 1'b1, "R3");
    send(1'b0, 24'hFFFFFE, 16'h0, 1'b1, "R6");

    // Mode 2: host-owned memory, DSP asks for SRAM throughout
    idle(3);
    mode = 2'd2;
    dsp_req = 4'b0001;
    @(negedge clk);
    chk(dsp_gnt[0] == 1'b0, "R4", "dsp locked out of sram", 32'(dsp_gnt), 32'd0);
    send(1'b0, 24'h000480, 16'h0, 1'b0, "R4");
    wait_rsp(0, lat, dc);
    chk(lat == 2 && dc == 0, "R4", "owned sram latency/dsp grants", 32'(lat * 16 + dc), 32'h20);
    send(1'b0, 24'h040020, 16'h0, 1'b1, "R4");
    send(1'b0, 24'h300000, 16'h0, 1'b1, "R4");
    send(1'b0, 24'h070000, 16'h0, 1'b1, "R6");

    // Mode 3: host-owned peripheral
    idle(3);
    mode = 2'd3;
    dsp_req = 4'b1000;
    @(negedge clk);
    chk(dsp_gnt[3] == 1'b0, "R5", "dsp locked out of pub", 32'(dsp_gnt), 32'd0);
    send(1'b1, 24'hF10000, 16'hC0DE, 1'b0, "R5");
    wait_rsp(3, lat, dc);
    chk(lat == 2 && dc == 0, "R5", "owned pub latency/dsp grants", 32'(lat * 16 + dc), 32'h20);
    send(1'b0, 24'h100000, 16'h0, 1'b1, "R5");
    send(1'b0, 24'hF80040, 16'h0, 1'b1, "R6");

    // Shared memory with DSP contending for SRAM
    idle(3);
    mode = 2'd0;
    dsp_req = 4'b0001;
    @(negedge clk);
    chk(dsp_gnt == 4'b0001, "R9", "dsp alone granted", 32'(dsp_gnt), 32'd1);
    send(1'b0, 24'h000010, 16'h0, 1'b0, "R9");
    wait_rsp(0, lat, dc);
    chk(lat == 2 && dc == 0, "R9", "first contended: host first", 32'(lat * 16 + dc), 32'h20);
    send(1'b0, 24'h000020, 16'h0, 1'b0, "R9");
    wait_rsp(0, lat, dc);
    chk(lat == 3 && dc == 1, "R9", "second contended: dsp one cycle", 32'(lat * 16 + dc), 32'h31);
    dsp_req = 4'b0000;

    // Back-pressure on the response
    idle(2);
    rsp_ready = 1'b0;
    send(1'b0, 24'h000040, 16'h0, 1'b0, "R1");
    idle(4);
    chk(rsp_valid && !req_ready && stat_busy, "R1", "held response blocks accept",
        {rsp_valid, req_ready, stat_busy}, 32'b101);
    held = rsp_rdata;
    idle(2);
    chk(rsp_rdata == held && rsp_valid, "R1", "held data stable", 32'(rsp_rdata), 32'(held));
    @(posedge clk);
    #1 rsp_ready = 1'b1;
    idle(3);
    chk(stat_busy == 1'b0, "R11", "busy cleared after take", 32'(stat_busy), 32'd0);
    chk(sb.size() == 0, "R1", "all responses returned", 32'(sb.size()), 32'd0);
    finish_run();
  end
endmodule